// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital control front end of a 7-bit step attenuator. It drives a 7-bit attenuation code to the switch core. Each code step is 0.25 dB. Bits 0 through 6 weigh 0.25, 0.5, 1, 2, 4, 8 and 16 dB. Code 0x00 is the insertion-loss reference and code 0x7F is 31.75 dB. Every input is sampled on a fast system clock through a two-flop synchronizer, and all edge detection is done in that clock domain.

A mode pin chooses where the code comes from:
- **Serial:** an 8-bit shift register loaded one bit at a time and copied to the output through a latch.
- **Parallel:** a 7-bit bus, taken either as a single capture per latch pulse or, with the latch enable held high, continuously.

The one latch-enable pin serves all of these paths. Its meaning depends on the mode.

After power-on reset the output is held at maximum attenuation. In serial or pulsed-parallel use it stays there until a latch enable rising edge is seen. If latch enable is already high at power-up in parallel mode, the output waits for a power-up delay counter to expire and then follows the bus.

Top module: `step_atten_ctrl`

## Requirements
- R1: The mode input selects the source: 1 takes the code from the serial shift register, 0 takes it from the parallel bus; the unselected source has no effect on the output.
- R2: The serial register is 8 bits and loads least significant bit first. The bit shifted in last ends in bit 7, which is discarded. Bits 6..0 form the code.
- R3: The shift register advances only on a rising serial clock edge seen while latch enable is low; serial clock edges while latch enable is high leave it unchanged.
- R4: In serial mode, while latch enable is high (and power-up hold has ended), the output equals bits 6..0 of the shift register.
- R5: While the synchronized latch enable is low the output does not change, whatever happens on the serial inputs or on the parallel bus.
- R6: In parallel mode a high pulse on latch enable captures the bus; the value present when latch enable falls is held afterwards.
- R7: In parallel mode with latch enable held high, the output tracks the bus continuously.
- R8: After reset in serial mode, or with latch enable low, the output is 0x7F and stays so, regardless of elapsed time, until the first latch enable rising edge.
- R9: After reset in parallel mode with latch enable high, the output is 0x7F for PUP_CYCLES system clocks and then takes the bus value.
- R10: An input change is visible at the output on the third rising system clock edge after it (two synchronizer stages plus the output register). The serial clock must have high and low phases of at least 2 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every other input |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mode_ser | input | 1 | 1 = serial source, 0 = parallel source |
| par_bus | input | 7 | Parallel attenuation code |
| ser_data | input | 1 | Serial data, least significant bit first |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| latch_en | input | 1 | Latch enable, shared by all modes |
| atten | output | 7 | Attenuation code to the switch core, 0.25 dB per step |

## Verification
The hardest case to reach is the direct-mode power-up window. It needs latch enable high before reset is released, so that no rising edge is ever seen. The bench therefore reapplies reset several times with different mode and latch-enable levels. It samples the output a few cycles before and after the shortened power-up count, and checks that serial mode with latch enable held high never leaves maximum attenuation on its own. Bit 7 of the serial word is driven opposite to bit 0 in every one of the 128 swept words, to show that it is discarded.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;
    localparam int ATT_W = 7;
    localparam int SR_W  = ATT_W + 1;

    typedef logic [ATT_W-1:0] att_code_t;

    localparam att_code_t ATT_MAX = '1;

    typedef struct packed {
        att_code_t atten;
        logic      pup;
        logic      le_prev;
        logic      sclk_prev;
    } ctrl_state_t;
endpackage

// File: rtl/sa_sync.sv
module sa_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] sync_q, sync_d;

    always_comb begin
        meta_d = din;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/sa_shift.sv
module sa_shift #(
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            din,
    output logic [SR_W-2:0] word
);
    logic [SR_W-1:0] sr_q, sr_d;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) begin
            sr_d = {din, sr_q[SR_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word = sr_q[SR_W-2:0];
endmodule

// File: rtl/sa_pup_timer.sv
module sa_pup_timer #(
    parameter int LIMIT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == LIM);
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import step_atten_pkg::*;
#(
    parameter int PUP_CYCLES = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ser,
    input  logic [ATT_W-1:0] par_bus,
    input  logic             ser_data,
    input  logic             ser_clk,
    input  logic             latch_en,
    output logic [ATT_W-1:0] atten
);
    localparam int IN_W = ATT_W + 4;
    localparam logic [IN_W-1:0] IN_RST = IN_W'(1);

    logic [IN_W-1:0] raw_in, syn_in;
    logic            mode_s, sd_s, sclk_s, le_s;
    att_code_t       par_s;
    att_code_t       sr;
    logic            tmr_done;
    logic            sclk_rise, le_rise, shift_en;
    logic            pup;

    ctrl_state_t st_q, st_d;

    assign raw_in = {mode_ser, par_bus, ser_data, ser_clk, latch_en};

    sa_sync #(.W(IN_W), .RST_VAL(IN_RST)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (syn_in)
    );

    assign {mode_s, par_s, sd_s, sclk_s, le_s} = syn_in;

    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign le_rise   = le_s & ~st_q.le_prev;
    assign shift_en  = sclk_rise & ~le_s;

    sa_shift #(.SR_W(SR_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .din     (sd_s),
        .word    (sr)
    );

    sa_pup_timer #(.LIMIT(PUP_CYCLES)) tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .done (tmr_done)
    );

    always_comb begin
        st_d           = st_q;
        st_d.le_prev   = le_s;
        st_d.sclk_prev = sclk_s;
        if (le_rise || (tmr_done && le_s && !mode_s)) begin
            st_d.pup = 1'b0;
        end
        if (st_d.pup) begin
            st_d.atten = ATT_MAX;
        end else if (le_s) begin
            st_d.atten = mode_s ? sr : par_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.atten     <= ATT_MAX;
            st_q.pup       <= 1'b1;
            st_q.le_prev   <= 1'b1;
            st_q.sclk_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pup   = st_q.pup;
    assign atten = st_q.atten;
endmodule

// File: rtl/step_atten_ctrl_chk.sv
module step_atten_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       le_s,
    input logic       mode_s,
    input logic [6:0] par_s,
    input logic [6:0] sr,
    input logic [6:0] atten,
    input logic       pup,
    input logic       tmr_done
);
    a_r5_frozen_le_low: assert property (@(posedge clk) disable iff (!rst_n)
        !le_s |=> $stable(atten));

    a_r3_sr_still_le_high: assert property (@(posedge clk) disable iff (!rst_n)
        le_s |=> $stable(sr));

    a_r8_max_in_pup: assert property (@(posedge clk) disable iff (!rst_n)
        pup |-> atten == 7'h7F);

    a_r4_serial_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (le_s && !pup && mode_s) |=> atten == $past(sr));

    a_r7_parallel_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (le_s && !pup && !mode_s) |=> atten == $past(par_s));

    a_r9_timer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |=> tmr_done);
endmodule

bind step_atten_ctrl step_atten_ctrl_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .le_s    (le_s),
    .mode_s  (mode_s),
    .par_s   (par_s),
    .sr      (sr),
    .atten   (atten),
    .pup     (pup),
    .tmr_done(tmr_done)
);

// File: tb/step_atten_ctrl_tb_top.sv
module step_atten_ctrl_tb_top;
    localparam int PUP = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_ser = 1'b1;
    logic [6:0] par_bus = '0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       latch_en = 1'b0;
    logic [6:0] atten;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    step_atten_ctrl #(.PUP_CYCLES(PUP)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_ser(mode_ser),
        .par_bus (par_bus),
        .ser_data(ser_data),
        .ser_clk (ser_clk),
        .latch_en(latch_en),
        .atten   (atten)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [6:0] exp);
        n_tests++;
        if (atten !== exp) begin
            n_fail++;
            $display("FAIL %s: atten=%h expected=%h", req, atten, exp);
        end
    endtask

    task automatic do_reset(input logic m, input logic le);
        rst_n = 1'b0;
        mode_ser = m;
        latch_en = le;
        ser_clk = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic shift_word(input logic [7:0] w);
        for (int b = 0; b < 8; b++) begin
            ser_data = w[b];
            ser_clk = 1'b0;
            step(4);
            ser_clk = 1'b1;
            step(4);
        end
        ser_clk = 1'b0;
        step(4);
    endtask

    task automatic pulse_le();
        latch_en = 1'b1;
        step(6);
        latch_en = 1'b0;
        step(5);
    endtask

    initial begin
        // serial mode, latch enable low at power-up
        do_reset(1'b1, 1'b0);
        step(1);
        check("R8 reset value", 7'h7F);
        step(PUP + 10);
        check("R8 no timed release in serial", 7'h7F);
        shift_word(8'h25);
        check("R5 R8 shifting keeps max", 7'h7F);
        par_bus = 7'h11;
        pulse_le();
        check("R2 R4 R1 first serial load", 7'h25);

        // full serial sweep, bit 7 opposite to bit 0
        for (int c = 0; c < 128; c++) begin
            logic [6:0] prev;
            prev = atten;
            shift_word({~c[0], c[6:0]});
            check("R5 serial shift no change", prev);
            par_bus = ~c[6:0];
            pulse_le();
            check("R2 serial sweep", c[6:0]);
        end

        // R3: serial clock edges with latch enable high are ignored
        shift_word(8'h0A);
        latch_en = 1'b1;
        step(5);
        check("R4 transparent serial", 7'h0A);
        for (int b = 0; b < 8; b++) begin
            ser_data = 1'b1;
            ser_clk = 1'b1; step(4);
            ser_clk = 1'b0; step(4);
        end
        check("R3 no shift with le high", 7'h0A);
        latch_en = 1'b0;
        step(5);
        pulse_le();
        check("R3 register unchanged after", 7'h0A);

        // latched parallel sweep
        mode_ser = 1'b0;
        step(5);
        check("R1 R5 mode switch with le low", 7'h0A);
        for (int c = 0; c < 128; c++) begin
            par_bus = c[6:0];
            pulse_le();
            par_bus = ~c[6:0];
            step(5);
            check("R6 latched parallel", c[6:0]);
        end

        // direct parallel sweep
        latch_en = 1'b1;
        for (int c = 0; c < 128; c++) begin
            par_bus = c[6:0];
            step(5);
            check("R7 direct follow", c[6:0]);
        end

        // R10 latency: change at a negedge, new value on third posedge
        par_bus = 7'h33;
        step(5);
        par_bus = 7'h4C;
        step(2);
        check("R10 old value after two edges", 7'h33);
        step(1);
        check("R10 new value after three edges", 7'h4C);

        // direct power-up
        par_bus = 7'h1B;
        do_reset(1'b0, 1'b1);
        step(PUP - 5);
        check("R9 max during delay", 7'h7F);
        step(12);
        check("R9 bus after delay", 7'h1B);
        par_bus = 7'h62;
        step(5);
        check("R9 R7 follows after delay", 7'h62);

        // serial mode with latch enable high at power-up
        do_reset(1'b1, 1'b1);
        step(PUP + 20);
        check("R8 serial le high stays max", 7'h7F);
        latch_en = 1'b0;
        step(5);
        shift_word(8'h03);
        pulse_le();
        check("R8 released by rising edge", 7'h03);

        // latched parallel power-up with le low
        par_bus = 7'h00;
        do_reset(1'b0, 1'b0);
        step(PUP + 20);
        check("R8 latched parallel stays max", 7'h7F);
        par_bus = 7'h00;
        pulse_le();
        check("R8 latched parallel first capture", 7'h00);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule